// File: doc/BRIEF.md
# Reset Cause Status Flags

This block keeps three sticky status bits that software inspects after it starts running, to learn what brought it there: a cold-start flag (`st_boot`, 0 after a power-up), a watchdog flag (`st_nowdt`, 0 after a watchdog event) and an awake flag (`st_awake`, 0 after the core slept). Each reset or wake-up event rewrites these bits in its own way, so the combination left behind identifies the event. The two power-management instructions (enter sleep, clear watchdog) also move the watchdog and awake flags.

Event inputs are single-cycle strobes sampled on the rising clock edge. When several arrive together, a fixed priority picks one. Software may set the cold-start flag through a write strobe. It reads the flag back inside a data word. A combinational decoder turns the three flags into a cause code and raises a separate illegal indication for combinations that no event sequence should produce. All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `reset_cause_flags`

## Requirements
- R1: While `rst_n` is low, the flags read `st_boot`=0, `st_nowdt`=1, `st_awake`=1. `rd_data` is 0 and `cause` is 0.
- R2: A cold-start strobe sets the flags to boot=0, nowdt=1, awake=1 at the next edge. It overrides every other input in that cycle. No other input can clear `st_boot`.
- R3: A watchdog-reset strobe clears `st_nowdt`, sets `st_awake` and leaves `st_boot` unchanged.
- R4: A watchdog-wake strobe clears both `st_nowdt` and `st_awake` and leaves `st_boot` unchanged.
- R5: An external reset while running leaves all three flags unchanged.
- R6: An external-reset or interrupt wake from sleep sets `st_nowdt`, clears `st_awake` and leaves `st_boot` unchanged.
- R7: When no reset event is present, a sleep operation sets `st_nowdt` and clears `st_awake`. In the same situation, a watchdog-clear operation sets both flags.
- R8: A write with `sw_wr_data[POR_BIT]`=1 sets `st_boot`, but only in a cycle with no reset event. A write with that bit at 0 has no effect. Other data bits are ignored. Writes and operations in the same cycle both take effect.
- R9: `rd_data` carries `st_boot` at bit `POR_BIT` (default 1). All other bits read 0.
- R10: `cause` is decoded from (boot, nowdt, awake) as follows. If boot=0 and either nowdt or awake is 0, `cause` is 5 and `illegal` is 1. Otherwise boot=0 gives 0 (power-up). When boot=1, the values are 1 for (0,1) (watchdog reset), 2 for (0,0) (watchdog wake), 3 for (1,1) (external reset while running) and 4 for (1,0) (wake from sleep). `illegal` is 0 for every code except 5.
- R11: Among events other than cold start, the priority runs from highest to lowest as watchdog reset, watchdog wake, external reset while running, wake from sleep, then the sleep operation and then the watchdog-clear operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, loads the power-up flag state |
| ev_cold_start | input | 1 | Power-up reset strobe |
| ev_wdog_reset | input | 1 | Watchdog time-out while running |
| ev_wdog_wake | input | 1 | Watchdog time-out during sleep |
| ev_ext_reset_run | input | 1 | External reset while running |
| ev_ext_wake | input | 1 | External reset or interrupt wake during sleep |
| op_sleep | input | 1 | Sleep operation executed |
| op_wdog_clear | input | 1 | Watchdog-clear operation executed |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | DATA_W | Software write data |
| rd_data | output | DATA_W | Status word holding the cold-start flag |
| st_boot | output | 1 | Cold-start flag |
| st_nowdt | output | 1 | Watchdog flag |
| st_awake | output | 1 | Awake flag |
| cause | output | 3 | Decoded cause code |
| illegal | output | 1 | Impossible flag combination |

## Verification
The bench builds the block with its defaults: an 8-bit status word and the flag at bit 1. With those defaults, writes that set only the neighbouring bits can be checked to have no effect, and the zero reads of the other seven bits are checked. The walk drives the flags through every one of the five legal causes. It also reaches the illegal combinations, by raising watchdog and wake events while the cold-start flag is still 0. It stacks events in single cycles to exercise each step of the priority.

// File: rtl/rcf_pkg.sv
package rcf_pkg;
  localparam int EV_COLD      = 0;
  localparam int EV_WDOG_RST  = 1;
  localparam int EV_WDOG_WAKE = 2;
  localparam int EV_EXT_RUN   = 3;
  localparam int EV_EXT_WAKE  = 4;
  localparam int EV_SLEEP     = 5;
  localparam int EV_WDOG_CLR  = 6;
  localparam int NUM_EV       = 7;
  localparam int NUM_RST_EV   = 5;

  typedef struct packed {
    logic boot;
    logic nowdt;
    logic awake;
  } flags_t;

  typedef enum logic [2:0] {
    CAUSE_POWER_UP  = 3'd0,
    CAUSE_WDOG_RST  = 3'd1,
    CAUSE_WDOG_WAKE = 3'd2,
    CAUSE_EXT_RUN   = 3'd3,
    CAUSE_EXT_WAKE  = 3'd4,
    CAUSE_ILLEGAL   = 3'd5
  } cause_t;

  localparam flags_t FLAGS_COLD = '{boot: 1'b0, nowdt: 1'b1, awake: 1'b1};
endpackage

// File: rtl/rcf_evt_prio.sv
module rcf_evt_prio #(
  parameter int N = 7
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  logic seen;

  // index 0 is the strongest request
  always_comb begin
    seen  = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      grant[i] = req[i] & ~seen;
      seen     = seen | req[i];
    end
  end
endmodule

// File: rtl/rcf_flag_next.sv
module rcf_flag_next
  import rcf_pkg::*;
(
  input  flags_t              cur,
  input  logic [NUM_EV-1:0]   grant,
  input  logic                rst_present,
  input  logic                wr_set,
  output flags_t              nxt
);
  always_comb begin
    nxt = cur;
    if (grant[EV_COLD]) begin
      nxt = FLAGS_COLD;
    end else if (grant[EV_WDOG_RST]) begin
      nxt.nowdt = 1'b0;
      nxt.awake = 1'b1;
    end else if (grant[EV_WDOG_WAKE]) begin
      nxt.nowdt = 1'b0;
      nxt.awake = 1'b0;
    end else if (grant[EV_EXT_RUN]) begin
      nxt = cur;
    end else if (grant[EV_EXT_WAKE]) begin
      nxt.nowdt = 1'b1;
      nxt.awake = 1'b0;
    end else if (grant[EV_SLEEP]) begin
      nxt.nowdt = 1'b1;
      nxt.awake = 1'b0;
    end else if (grant[EV_WDOG_CLR]) begin
      nxt.nowdt = 1'b1;
      nxt.awake = 1'b1;
    end
    if (!rst_present && wr_set) begin
      nxt.boot = 1'b1;
    end
  end
endmodule

// File: rtl/rcf_cause_dec.sv
module rcf_cause_dec
  import rcf_pkg::*;
(
  input  flags_t  fl,
  output cause_t  cause,
  output logic    illegal
);
  always_comb begin
    illegal = !fl.boot && (!fl.nowdt || !fl.awake);
    if (illegal) begin
      cause = CAUSE_ILLEGAL;
    end else if (!fl.boot) begin
      cause = CAUSE_POWER_UP;
    end else begin
      unique case ({fl.nowdt, fl.awake})
        2'b01:   cause = CAUSE_WDOG_RST;
        2'b00:   cause = CAUSE_WDOG_WAKE;
        2'b11:   cause = CAUSE_EXT_RUN;
        default: cause = CAUSE_EXT_WAKE;
      endcase
    end
  end
endmodule

// File: rtl/reset_cause_flags.sv
module reset_cause_flags
  import rcf_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int POR_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_cold_start,
  input  logic              ev_wdog_reset,
  input  logic              ev_wdog_wake,
  input  logic              ev_ext_reset_run,
  input  logic              ev_ext_wake,
  input  logic              op_sleep,
  input  logic              op_wdog_clear,
  input  logic              sw_wr_en,
  input  logic [DATA_W-1:0] sw_wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              st_boot,
  output logic              st_nowdt,
  output logic              st_awake,
  output logic [2:0]        cause,
  output logic              illegal
);
  localparam logic [DATA_W-1:0] SEL_MASK = DATA_W'(1) << POR_BIT;

  logic [NUM_EV-1:0] req;
  logic [NUM_EV-1:0] grant;
  logic              rst_present;
  logic              wr_set;
  logic              unused_wr_bits;
  flags_t            fl_q;
  flags_t            fl_d;
  cause_t            cause_w;

  assign req[EV_COLD]      = ev_cold_start;
  assign req[EV_WDOG_RST]  = ev_wdog_reset;
  assign req[EV_WDOG_WAKE] = ev_wdog_wake;
  assign req[EV_EXT_RUN]   = ev_ext_reset_run;
  assign req[EV_EXT_WAKE]  = ev_ext_wake;
  assign req[EV_SLEEP]     = op_sleep;
  assign req[EV_WDOG_CLR]  = op_wdog_clear;

  assign rst_present    = |req[NUM_RST_EV-1:0];
  assign wr_set         = sw_wr_en && sw_wr_data[POR_BIT];
  assign unused_wr_bits = ^(sw_wr_data & ~SEL_MASK);

  rcf_evt_prio #(.N(NUM_EV)) u_prio (
    .req   (req),
    .grant (grant)
  );

  rcf_flag_next u_next (
    .cur         (fl_q),
    .grant       (grant),
    .rst_present (rst_present),
    .wr_set      (wr_set),
    .nxt         (fl_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fl_q <= FLAGS_COLD;
    else        fl_q <= fl_d;
  end

  rcf_cause_dec u_dec (
    .fl      (fl_q),
    .cause   (cause_w),
    .illegal (illegal)
  );

  assign cause    = cause_w;
  assign st_boot  = fl_q.boot;
  assign st_nowdt = fl_q.nowdt;
  assign st_awake = fl_q.awake;

  // status word: flag at its fixed position, zeros elsewhere
  for (genvar b = 0; b < DATA_W; b++) begin : g_rd
    if (b == POR_BIT) begin : g_flag
      assign rd_data[b] = fl_q.boot;
    end else begin : g_zero
      assign rd_data[b] = 1'b0;
    end
  end

  assert_cold_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cold_start |=> (!st_boot && st_nowdt && st_awake));
  assert_boot_only_falls_on_cold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_boot) |-> $past(ev_cold_start));
  assert_wdog_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_cold_start && ev_wdog_reset)
    |=> (st_boot == $past(st_boot) && !st_nowdt && st_awake));
  assert_wdog_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_cold_start && !ev_wdog_reset && ev_wdog_wake)
    |=> (st_boot == $past(st_boot) && !st_nowdt && !st_awake));
  assert_ext_run_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_cold_start && !ev_wdog_reset && !ev_wdog_wake && ev_ext_reset_run)
    |=> ($stable(st_boot) && $stable(st_nowdt) && $stable(st_awake)));
  assert_ext_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_cold_start && !ev_wdog_reset && !ev_wdog_wake && !ev_ext_reset_run && ev_ext_wake)
    |=> (st_boot == $past(st_boot) && st_nowdt && !st_awake));
  assert_sleep_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_present && op_sleep) |=> (st_nowdt && !st_awake));
  assert_write_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_present && sw_wr_en && sw_wr_data[POR_BIT]) |=> st_boot);
  assert_write_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_present && !ev_cold_start) |=> (st_boot == $past(st_boot)));
endmodule

// File: tb/reset_cause_flags_tb.sv
`timescale 1ns/1ps
module reset_cause_flags_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] ev = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       st_boot, st_nowdt, st_awake, illegal;
  logic [2:0] cause;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int m_boot, m_nowdt, m_awake;

  always #2.5 clk = ~clk;

  reset_cause_flags u_dut (
    .clk(clk), .rst_n(rst_n),
    .ev_cold_start(ev[0]), .ev_wdog_reset(ev[1]), .ev_wdog_wake(ev[2]),
    .ev_ext_reset_run(ev[3]), .ev_ext_wake(ev[4]),
    .op_sleep(ev[5]), .op_wdog_clear(ev[6]),
    .sw_wr_en(wr_en), .sw_wr_data(wr_data),
    .rd_data(rd_data), .st_boot(st_boot), .st_nowdt(st_nowdt),
    .st_awake(st_awake), .cause(cause), .illegal(illegal)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_cause();
    if (m_boot == 0 && (m_nowdt == 0 || m_awake == 0)) return 5;
    if (m_boot == 0) return 0;
    if (m_nowdt == 0 && m_awake == 1) return 1;
    if (m_nowdt == 0 && m_awake == 0) return 2;
    if (m_nowdt == 1 && m_awake == 1) return 3;
    return 4;
  endfunction

  task automatic compare_all(input string tag);
    int ec;
    ec = exp_cause();
    chk(tag, "flags", {29'd0, st_boot, st_nowdt, st_awake}, m_boot * 4 + m_nowdt * 2 + m_awake);
    chk("R9", "rd_data", int'(rd_data), m_boot * 2);
    chk("R10", "cause", int'(cause), ec);
    chk("R10", "illegal", int'(illegal), (ec == 5) ? 1 : 0);
  endtask

  // called at a falling edge; drives, lets one rising edge pass, compares
  task automatic cyc(input logic [6:0] e, input logic w, input logic [7:0] d, input string tag);
    ev = e; wr_en = w; wr_data = d;
    @(posedge clk);
    #1;
    if (e[0]) begin m_boot = 0; m_nowdt = 1; m_awake = 1; end
    else if (e[1]) begin m_nowdt = 0; m_awake = 1; end
    else if (e[2]) begin m_nowdt = 0; m_awake = 0; end
    else if (e[3]) begin end
    else if (e[4]) begin m_nowdt = 1; m_awake = 0; end
    else begin
      if (e[5]) begin m_nowdt = 1; m_awake = 0; end
      else if (e[6]) begin m_nowdt = 1; m_awake = 1; end
      if (w && d[1]) m_boot = 1;
    end
    @(negedge clk);
    compare_all(tag);
    ev = '0; wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    m_boot = 0; m_nowdt = 1; m_awake = 1;
    repeat (3) @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    cyc(7'b0000000, 1'b0, 8'h00, "R1");
    cyc(7'b0000000, 1'b1, 8'hFD, "R8");
    cyc(7'b0000000, 1'b1, 8'h02, "R8");
    cyc(7'b0000010, 1'b0, 8'h00, "R3");
    cyc(7'b0001000, 1'b0, 8'h00, "R5");
    cyc(7'b0100000, 1'b0, 8'h00, "R7");
    cyc(7'b0000100, 1'b0, 8'h00, "R4");
    cyc(7'b1000000, 1'b0, 8'h00, "R7");
    cyc(7'b0010000, 1'b0, 8'h00, "R6");
    cyc(7'b1000000, 1'b0, 8'h00, "R7");
    cyc(7'b1111111, 1'b1, 8'hFF, "R2");
    cyc(7'b0001000, 1'b1, 8'h02, "R8");
    cyc(7'b0000010, 1'b0, 8'h00, "R10");
    cyc(7'b0010000, 1'b0, 8'h00, "R10");
    cyc(7'b1000000, 1'b0, 8'h00, "R7");
    cyc(7'b0000110, 1'b0, 8'h00, "R11");
    cyc(7'b0011000, 1'b0, 8'h00, "R11");
    cyc(7'b0010100, 1'b0, 8'h00, "R11");
    cyc(7'b1110000, 1'b0, 8'h00, "R11");
    cyc(7'b1100000, 1'b0, 8'h00, "R11");
    cyc(7'b0100000, 1'b1, 8'h02, "R8");
    cyc(7'b1000000, 1'b0, 8'h00, "R7");
    cyc(7'b0001000, 1'b0, 8'h00, "R5");
    cyc(7'b0000001, 1'b0, 8'h00, "R2");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule